// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block is a bus master for an external memory system in which the low address byte and the data byte share one port. It takes one request at a time from a valid/ready request port: a program fetch, a data read or a data write, each with a 16-bit address and, for writes, a data byte. For each request it runs one bus cycle on the external pins. The cycle raises an address latch enable, puts the address on the pins, releases or reuses the shared port, and then asserts one of three active-low strobes. All phases are counted in clock periods.

The high address byte has its own output and stays valid for the whole cycle. The low byte appears on the shared port long enough for an external transparent latch to capture it when the latch enable falls. A programmable wait count lengthens the strobe phase so that slower memories can be used. Read data is captured on the clock edge where the strobe returns high. It comes back as a one-cycle done pulse and then holds its value. The done pulse has no back-pressure, so the requester must take it in the cycle it appears. A request is taken when `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low.

Top module: `xbus_seq`

## Requirements
- R1: After reset, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `ad_oe` is low, `busy` is low and `req_ready` is high.
- R2: A cycle lasts 6+W periods, where W is the wait count. It is numbered from period 0. `ale` is high in periods 0 and 1 only. `ad_out` carries the address low byte with `ad_oe` high in periods 1 and 2. `addr_hi` carries the address high byte from period 0 to the end of the cycle.
- R3: Exactly one strobe is low, and only in periods 3 to 5+W, which is 3+W periods. `req_kind` 2'b00 uses `psen_n` (program read), 2'b01 uses `rd_n` (data read) and 2'b10 uses `wr_n` (data write). At no time is more than one strobe low, and no strobe is low while `ale` is high.
- R4: In read cycles, `ad_oe` is low in period 0 and during the whole strobe phase.
- R5: For reads, the byte on `ad_in` in the last strobe period appears on `rsp_data` together with a one-cycle `rsp_valid` pulse, in the period after the strobe rises. `rsp_data` then stays unchanged until the next `rsp_valid`.
- R6: In a write cycle, `ad_out` carries the write byte with `ad_oe` high during every strobe-low period.
- R7: `req_ready` is high when the block is idle and in the last period of a cycle. `busy` is high from period 0 through the last period. Requests held valid back to back start a new cycle every 6+W periods.
- R8: A request with `req_kind` 2'b11 starts no cycle: `busy`, `ale` and all strobes stay inactive.
- R9: The wait count `cfg_wait` (0 to 7 by default) is sampled when a request is accepted. Each unit adds one period to the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all phases counted in its periods |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait | input | WAIT_W | Extra strobe periods, taken at request acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | 00 program read, 01 data read, 10 data write, 11 none |
| req_addr | input | ADDR_W | Full byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | DATA_W | Last read byte, held |
| busy | output | 1 | A bus cycle is running |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | ADDR_W-DATA_W | Upper address byte |
| ad_out | output | DATA_W | Shared port, outgoing value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | DATA_W | Shared port, incoming value |

## Verification
The hardest situation to reach is a back-to-back pair of cycles. Here the next cycle starts in the same period in which the earlier cycle's read byte is returned, and the held byte must survive the whole following cycle. The bench holds `req_valid` high across the boundary and changes the address once the first request is taken. It then measures the distance between latch-enable rises and reads `rsp_data` in the middle of the second cycle. A sweep over every wait count and every cycle kind, with a latch and memory model in the bench, covers the strobe-width and address-hold corners.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    K_PROG = 2'b00,
    K_DRD  = 2'b01,
    K_DWR  = 2'b10,
    K_NONE = 2'b11
  } xkind_e;

  localparam int unsigned BASE_LEN  = 6;  // periods in a cycle without waits
  localparam int unsigned ADDR_LAST = 2;  // last period the low address is driven
  localparam int unsigned STB_FIRST = 3;  // first strobe-low period
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_in,
  output logic              active,
  output logic [CNT_W-1:0]  cnt,
  output logic              last
);
  import xbus_pkg::*;

  logic [WAIT_W-1:0] wait_q;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = CNT_W'(BASE_LEN - 1) + CNT_W'(wait_q);
  assign last     = active && (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      wait_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      wait_q <= wait_in;
    end else if (last) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       kind,
  output logic             ale,
  output logic             in_strobe,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n
);
  import xbus_pkg::*;

  always_comb begin
    ale       = active && (cnt < CNT_W'(ADDR_LAST));
    in_strobe = active && (cnt >= CNT_W'(STB_FIRST));
    psen_n    = !(in_strobe && (kind == K_PROG));
    rd_n      = !(in_strobe && (kind == K_DRD));
    wr_n      = !(in_strobe && (kind == K_DWR));
  end
endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              active,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              in_strobe,
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out
);
  import xbus_pkg::*;

  logic addr_phase;
  logic wr_phase;

  always_comb begin
    addr_phase = active && (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(ADDR_LAST));
    wr_phase   = in_strobe && (kind == K_DWR);
    ad_oe      = addr_phase || wr_phase;
    if (addr_phase)    ad_out = addr_lo;
    else if (wr_phase) ad_out = wdata;
    else               ad_out = '0;
  end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic              is_read,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= last;
      if (last && is_read) rsp_data <= ad_in;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WAIT_W-1:0]        cfg_wait,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     busy,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in
);
  import xbus_pkg::*;

  localparam int unsigned MAX_LEN = BASE_LEN + (1 << WAIT_W) - 1;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN);

  logic              active, last, in_strobe, fire;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = !active || last;
  assign fire      = req_valid && req_ready && (req_kind != K_NONE);
  assign busy      = active;
  assign addr_hi   = addr_q[ADDR_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (fire) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  xbus_phase_ctr #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .start(fire), .wait_in(cfg_wait),
    .active(active), .cnt(cnt), .last(last)
  );

  xbus_strobe_gen #(.CNT_W(CNT_W)) stb_i (
    .active(active), .cnt(cnt), .kind(kind_q), .ale(ale),
    .in_strobe(in_strobe), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  xbus_port_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) mux_i (
    .active(active), .cnt(cnt), .in_strobe(in_strobe), .kind(kind_q),
    .addr_lo(addr_q[DATA_W-1:0]), .wdata(wdata_q),
    .ad_oe(ad_oe), .ad_out(ad_out)
  );

  xbus_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .last(last),
    .is_read(kind_q != K_DWR), .ad_in(ad_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rsp_valid,
  input logic [DATA_W-1:0]        rsp_data,
  input logic                     busy,
  input logic                     ale,
  input logic                     psen_n,
  input logic                     rd_n,
  input logic                     wr_n,
  input logic [ADDR_W-DATA_W-1:0] addr_hi,
  input logic [DATA_W-1:0]        ad_out,
  input logic                     ad_oe
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);
  a_r3_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));
  a_r4_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && ad_out == $past(ad_out)));
  a_r2_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable(addr_hi));
  a_r5_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!(psen_n && rd_n && wr_n)));
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_data));
  a_r6_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && psen_n && rd_n && wr_n && !ad_oe));
endmodule

bind xbus_seq xbus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .busy(busy), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe)
);

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_wait = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid, busy, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] rsp_data, addr_hi, ad_out, ad_in;
  logic [7:0] latch_q = '0;
  logic [7:0] ram [256];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  // External transparent latch and memories.
  always @(ale or ad_out) if (ale) latch_q = ad_out;
  assign ad_in = !psen_n ? rom_byte({addr_hi, latch_q}) :
                 !rd_n   ? ram[latch_q] : 8'hEE;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run_cycle(input logic [1:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input int w);
    int len, ale_cnt, stb_cnt, other_cnt, adr_bad, wr_bad, rd_oe_bad, busy_cnt, first_stb;
    logic [7:0] exp_d;
    len = 6 + w; ale_cnt = 0; stb_cnt = 0; other_cnt = 0; adr_bad = 0;
    wr_bad = 0; rd_oe_bad = 0; busy_cnt = 0; first_stb = -1;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd; cfg_wait = 3'(w);
    @(negedge clk);
    req_valid = 0; cfg_wait = 3'(7 - w);  // R9: later changes must not matter
    for (int n = 0; n < len; n++) begin
      logic mine, others;
      if (n > 0) @(negedge clk);
      mine   = (k == 2'b00) ? !psen_n : (k == 2'b01) ? !rd_n : !wr_n;
      others = (k == 2'b00) ? (!rd_n || !wr_n) : (k == 2'b01) ? (!psen_n || !wr_n)
                            : (!psen_n || !rd_n);
      busy_cnt += busy;
      if (ale) begin
        ale_cnt++;
        if (n > 1) adr_bad++;
      end
      if (addr_hi != a[15:8]) adr_bad++;
      if ((n == 1 || n == 2) && (!ad_oe || ad_out != a[7:0])) adr_bad++;
      if (mine) begin
        stb_cnt++;
        if (first_stb < 0) first_stb = n;
        if (latch_q != a[7:0]) adr_bad++;
        if (k == 2'b10 && (!ad_oe || ad_out != wd)) wr_bad++;
      end
      if (others) other_cnt++;
      if (k != 2'b10 && (n == 0 || mine) && ad_oe) rd_oe_bad++;
    end
    chk(ale_cnt == 2, "R2 ale width", ale_cnt, 2);
    chk(adr_bad == 0, "R2 address presentation", adr_bad, 0);
    chk(stb_cnt == 3 + w && first_stb == 3, "R3/R9 strobe width", stb_cnt, 3 + w);
    chk(other_cnt == 0, "R3 other strobes idle", other_cnt, 0);
    chk(busy_cnt == len, "R7 busy span", busy_cnt, len);
    if (k == 2'b10) chk(wr_bad == 0, "R6 write data", wr_bad, 0);
    else chk(rd_oe_bad == 0, "R4 read float", rd_oe_bad, 0);
    @(negedge clk);
    chk(rsp_valid && !busy && req_ready, "R5/R7 done pulse", {rsp_valid, busy}, 2'b10);
    exp_d = (k == 2'b00) ? rom_byte(a) : ram[a[7:0]];
    if (k != 2'b10) chk(rsp_data == exp_d, "R5 read data", rsp_data, exp_d);
    else ram[a[7:0]] = wd;
    @(negedge clk);
    chk(!rsp_valid, "R5 pulse one cycle", rsp_valid, 0);
  endtask

  task automatic run_b2b(input logic [15:0] a, input logic [15:0] b, input int w);
    int len, rise0, rise1, nrise;
    logic prev;
    len = 6 + w; rise0 = -1; rise1 = -1; nrise = 0; prev = 0;
    @(negedge clk);
    req_valid = 1; req_kind = 2'b00; req_addr = a; cfg_wait = 3'(w);
    @(negedge clk);
    req_addr = b;
    for (int n = 0; n <= 2 * len; n++) begin
      if (n > 0) @(negedge clk);
      if (n == len) req_valid = 0;
      if (ale && !prev) begin
        if (nrise == 0) rise0 = n; else if (nrise == 1) rise1 = n;
        nrise++;
      end
      prev = ale;
      if (n == len) chk(rsp_valid && busy, "R7 overlap done/start", {rsp_valid, busy}, 2'b11);
      if (n == len + 3)
        chk(rsp_data == rom_byte(a), "R5 held during next cycle", rsp_data, rom_byte(a));
      if (n == 2 * len) begin
        chk(rsp_valid && rsp_data == rom_byte(b), "R5 second read", rsp_data, rom_byte(b));
      end
    end
    chk(nrise == 2 && rise1 - rise0 == len, "R7 back-to-back spacing", rise1 - rise0, len);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n && !ad_oe && !busy,
        "R1 reset outputs", {ale, psen_n, rd_n, wr_n, ad_oe, busy}, 6'b011100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy, "R1 ready after reset", req_ready, 1);

    for (int w = 0; w < 8; w++)
      for (int k = 0; k < 3; k++)
        for (int j = 0; j < 3; j++) begin
          logic [15:0] a;
          a = 16'(16'h1234 * (j + 1) + w * 16'h0101 + k * 16'h4321);
          run_cycle(2'(k), a, 8'(a[7:0] ^ 8'h3C ^ 8'(w)), w);
        end

    // Read-after-write through the bench RAM.
    run_cycle(2'b10, 16'h7F42, 8'hC9, 1);
    run_cycle(2'b01, 16'h0042, 8'h00, 0);

    // R8: reserved kind starts nothing.
    @(negedge clk);
    req_valid = 1; req_kind = 2'b11; req_addr = 16'hABCD;
    begin
      int act;
      act = 0;
      for (int n = 0; n < 10; n++) begin
        @(negedge clk);
        if (busy || ale || !psen_n || !rd_n || !wr_n || rsp_valid) act++;
      end
      chk(act == 0, "R8 reserved kind ignored", act, 0);
    end
    req_valid = 0;

    run_b2b(16'h2010, 16'h3020, 0);
    run_b2b(16'hF00F, 16'h0FF0, 2);
    run_b2b(16'h5555, 16'hAAAA, 7);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule